// File: doc/BRIEF.md
# Capture-Compare Timer with Output Flip-Flop

This block is a 16-bit up-counting timer that advances once every `PRE_DIV` clocks. Two 16-bit compare registers are checked against the counter. Each match raises its own one-cycle interrupt pulse. Software can also take a snapshot of the counter into a read-only capture register through a control bit.

A single flip-flop drives the timer output pin. Software can set, clear or invert it with a 2-bit command. It can also be inverted by compare-0 matches, compare-1 matches and software captures, and each of these three sources has its own enable.

All control goes through a byte-wide register port with eight addresses. Read data is registered and returned one clock after the read strobe. Reading the low byte of the capture register freezes its high byte, so that a low-then-high read pair returns one coherent 16-bit value.

Top module: `cct_timer`

Register map, byte addresses:

| Address | Contents |
|---|---|
| 0 | CTRL: bit0 timer run, bit1 prescaler run, bit2 capture-control bit |
| 1 | FFC: bits1:0 command (write-only, read back as 11), bit2 compare-0 toggle enable, bit3 compare-1 toggle enable, bit4 capture toggle enable, bit5 flip-flop value (read-only) |
| 2, 3 | Compare 0, low byte then high byte |
| 4, 5 | Compare 1, low byte then high byte |
| 6, 7 | Capture register, low byte then high byte |

## Requirements
- R1: The counter advances only while CTRL bit0 and bit1 are both 1. It is held at 0 whenever either bit is 0.
- R2: While running, the counter increments by one every `PRE_DIV` clocks. After k clocks of running it holds floor(k / `PRE_DIV`).
- R3: Writing CTRL with bit2 = 0 copies the counter value present before that write edge into the capture register.
- R4: Writing CTRL with bit2 = 1 captures when the stored bit2 is 0. It does not capture when the stored bit2 is already 1.
- R5: No capture occurs on a CTRL write while the stored prescaler run bit (CTRL bit1 before the write) is 0.
- R6: The capture register sits at address 6 (low byte) and address 7 (high byte), and writes to these addresses have no effect.
- R7: A read of address 6 latches the capture high byte. A later read of address 7 returns that latched byte, even if a capture occurs in between.
- R8: Each compare channel pulses its interrupt output for exactly one clock, in the clock in which the counter steps onto that channel's compare value.
- R9: Writing FFC bits1:0 = 00 inverts the flip-flop, 01 sets it, 10 clears it, and 11 leaves it unchanged. `tmr_out` and FFC bit5 show its value.
- R10: An enabled event source inverts the flip-flop: compare-0 or compare-1 interrupt one clock after the pulse, or a capture at its write edge. A disabled source leaves it unchanged.
- R11: After reset, CTRL reads 0x04, both compare registers read 0xFFFF, the capture register reads 0, and `tmr_out` and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, one clock per write |
| re | input | 1 | Read strobe, data returned on `rdata` one clock later |
| rdata | output | 8 | Registered read data |
| irq_cmp0 | output | 1 | Compare-0 match pulse |
| irq_cmp1 | output | 1 | Compare-1 match pulse |
| tmr_out | output | 1 | Timer output flip-flop |

## Verification
The assertions assume that `we` and `re` are never high together and that `addr` is stable while either strobe is high. The bench drives every access as a single one-clock strobe on the falling edge, so both conditions always hold.

The interrupt single-pulse property assumes that a compare value cannot be reached twice within two clocks. This holds for any `PRE_DIV` and a 16-bit counter. The bench also keeps every compare value far below the wrap point, so that a second match never falls inside a test window.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int TMR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int N_CMP  = 2;
  localparam int N_EV   = N_CMP + 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_FFC  = 3'd1,
    A_C0L  = 3'd2,
    A_C0H  = 3'd3,
    A_C1L  = 3'd4,
    A_C1H  = 3'd5,
    A_CPL  = 3'd6,
    A_CPH  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    FF_FLIP = 2'b00,
    FF_SET  = 2'b01,
    FF_CLR  = 2'b10,
    FF_KEEP = 2'b11
  } ff_cmd_e;
endpackage

// File: rtl/cct_core.sv
module cct_core
  import cct_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run_en,
  input  logic                        pre_en,
  input  logic [N_CMP-1:0][TMR_W-1:0] cmp,
  output logic [TMR_W-1:0]            cnt_q,
  output logic [N_CMP-1:0]            irq_q
);
  logic running;
  logic tick;
  logic [TMR_W-1:0] cnt_nx;

  assign running = run_en & pre_en;
  assign cnt_nx  = cnt_q + 1'b1;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign tick = running;
    end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] PLAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || !running)   pre_q <= '0;
        else if (pre_q == PLAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end
      assign tick = running && (pre_q == PLAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !running) cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_nx;
  end

  assert_stop_clears_R1: assert property (@(posedge clk) disable iff (rst)
    !(run_en && pre_en) |=> (cnt_q == '0));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    $past(running) |-> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

  genvar gi;
  generate
    for (gi = 0; gi < N_CMP; gi++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst) irq_q[gi] <= 1'b0;
        else     irq_q[gi] <= tick && (cnt_nx == cmp[gi]);
      end

      assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq_q[gi] |=> !irq_q[gi]);

      assert_irq_on_value_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_q[gi] && $stable(cmp[gi])) |-> (cnt_q == cmp[gi]));
    end
  endgenerate
endmodule

// File: rtl/cct_regs.sv
module cct_regs
  import cct_pkg::*;
#(
  parameter logic [TMR_W-1:0] CMP_RST = '1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        we,
  input  logic                        re,
  input  logic [TMR_W-1:0]            cnt,
  input  logic                        ff_val,
  output logic [BYTE_W-1:0]           rdata_q,
  output logic                        run_q,
  output logic                        pre_q,
  output logic [N_CMP-1:0][TMR_W-1:0] cmp_q,
  output logic [N_EV-1:0]             ev_en_q,
  output logic                        ff_wr,
  output logic [1:0]                  ff_cmd,
  output logic                        cap_fire
);
  logic              cap_bit_q;
  logic [TMR_W-1:0]  cap_q;
  logic [BYTE_W-1:0] hold_q;
  logic              wr_ctrl;

  assign wr_ctrl  = we && (addr == A_CTRL);
  assign cap_fire = wr_ctrl && pre_q && (!wdata[2] || !cap_bit_q);
  assign ff_wr    = we && (addr == A_FFC);
  assign ff_cmd   = wdata[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      pre_q     <= 1'b0;
      cap_bit_q <= 1'b1;
      cmp_q     <= {N_CMP{CMP_RST}};
      ev_en_q   <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_CTRL: begin
          run_q     <= wdata[0];
          pre_q     <= wdata[1];
          cap_bit_q <= wdata[2];
        end
        A_FFC:  ev_en_q         <= wdata[4:2];
        A_C0L:  cmp_q[0][7:0]   <= wdata;
        A_C0H:  cmp_q[0][15:8]  <= wdata;
        A_C1L:  cmp_q[1][7:0]   <= wdata;
        A_C1H:  cmp_q[1][15:8]  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cap_q <= '0;
    else if (cap_fire) cap_q <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      hold_q  <= '0;
    end else if (re) begin
      case (reg_addr_e'(addr))
        A_CTRL: rdata_q <= {5'b0, cap_bit_q, pre_q, run_q};
        A_FFC:  rdata_q <= {2'b0, ff_val, ev_en_q, FF_KEEP};
        A_C0L:  rdata_q <= cmp_q[0][7:0];
        A_C0H:  rdata_q <= cmp_q[0][15:8];
        A_C1L:  rdata_q <= cmp_q[1][7:0];
        A_C1H:  rdata_q <= cmp_q[1][15:8];
        A_CPL: begin
          rdata_q <= cap_q[7:0];
          hold_q  <= cap_q[15:8];
        end
        default: rdata_q <= hold_q;
      endcase
    end
  end

  assert_no_cap_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    !pre_q |=> $stable(cap_q));

  assert_cap_read_only_R6: assert property (@(posedge clk) disable iff (rst)
    (we && ((addr == A_CPL) || (addr == A_CPH))) |=> $stable(cap_q));

  assert_high_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (re && !we && (addr == A_CPH)) |=> (rdata_q == $past(hold_q)));
endmodule

// File: rtl/cct_outff.sv
module cct_outff
  import cct_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic [1:0]      cmd,
  input  logic [N_EV-1:0] ev,
  input  logic [N_EV-1:0] ev_en,
  output logic            ff_q
);
  logic flip;
  logic cmd_act;

  assign flip    = ^(ev & ev_en);
  assign cmd_act = cmd_wr && (ff_cmd_e'(cmd) != FF_KEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q <= 1'b0;
    end else if (cmd_act) begin
      case (ff_cmd_e'(cmd))
        FF_SET:  ff_q <= 1'b1;
        FF_CLR:  ff_q <= 1'b0;
        default: ff_q <= ~ff_q;
      endcase
    end else if (flip) begin
      ff_q <= ~ff_q;
    end
  end

  assert_cmd_set_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (cmd == 2'b01)) |=> ff_q);

  assert_cmd_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (cmd == 2'b10)) |=> !ff_q);

  assert_quiet_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr && ((ev & ev_en) == '0)) |=> $stable(ff_q));
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int                PRE_DIV = 4,
  parameter logic [TMR_W-1:0]  CMP_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_cmp0,
  output logic              irq_cmp1,
  output logic              tmr_out
);
  logic                        run_q;
  logic                        pre_q;
  logic [N_CMP-1:0][TMR_W-1:0] cmp_q;
  logic [N_EV-1:0]             ev_en_q;
  logic                        ff_wr;
  logic [1:0]                  ff_cmd;
  logic                        cap_fire;
  logic [TMR_W-1:0]            cnt_q;
  logic [N_CMP-1:0]            irq_q;
  logic                        ff_q;

  cct_regs #(.CMP_RST(CMP_RST)) regs_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .cnt(cnt_q), .ff_val(ff_q), .rdata_q(rdata), .run_q(run_q), .pre_q(pre_q),
    .cmp_q(cmp_q), .ev_en_q(ev_en_q), .ff_wr(ff_wr), .ff_cmd(ff_cmd),
    .cap_fire(cap_fire)
  );

  cct_core #(.PRE_DIV(PRE_DIV)) core_i (
    .clk(clk), .rst(rst), .run_en(run_q), .pre_en(pre_q), .cmp(cmp_q),
    .cnt_q(cnt_q), .irq_q(irq_q)
  );

  cct_outff outff_i (
    .clk(clk), .rst(rst), .cmd_wr(ff_wr), .cmd(ff_cmd),
    .ev({cap_fire, irq_q[1], irq_q[0]}), .ev_en(ev_en_q), .ff_q(ff_q)
  );

  assign irq_cmp0 = irq_q[0];
  assign irq_cmp1 = irq_q[1];
  assign tmr_out  = ff_q;
endmodule

// File: tb/cct_timer_tb_top.sv
module cct_timer_tb_top;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic       irq_cmp0, irq_cmp1, tmr_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_e = 0;
  int n0 = 0, n1 = 0, f0 = 0, f1 = 0;
  bit done = 0;

  cct_timer #(.PRE_DIV(D)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1), .tmr_out(tmr_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && irq_cmp0) begin if (n0 == 0) f0 = cyc; n0 = n0 + 1; end
    if (!rst && irq_cmp1) begin if (n1 == 0) f1 = cyc; n1 = n1 + 1; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    last_e = cyc + 1;
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic rd_cap(output int v);
    logic [7:0] lo, hi;
    rd(3'd6, lo);
    rd(3'd7, hi);
    v = {16'd0, hi, lo};
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] b;
    int v, e0, e1, e2, exp1, exp2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd(3'd0, b); chk("R11 ctrl", b, 8'h04);
    rd(3'd2, b); chk("R11 cmp0 lo", b, 8'hFF);
    rd(3'd5, b); chk("R11 cmp1 hi", b, 8'hFF);
    rd_cap(v);   chk("R11 capture", v, 0);
    chk("R11 tmr_out", tmr_out, 0);
    chk("R11 irqs", {irq_cmp1, irq_cmp0}, 0);

    // R6 writes to capture ignored
    wr(3'd6, 8'h5A); wr(3'd7, 8'hA5);
    rd_cap(v); chk("R6 capture read-only", v, 0);

    // R2 / R3 capture sweep over run lengths
    for (int n = 0; n < 15; n++) begin
      wr(3'd0, 8'h06);
      wr(3'd0, 8'h07); e0 = last_e;
      repeat (n) @(negedge clk);
      wr(3'd0, 8'h03); e1 = last_e;
      rd_cap(v); chk("R2 R3 capture count", v, (e1 - e0 - 1) / D);
    end

    // R4 write-1 capture only when bit holds 0
    wr(3'd0, 8'h06);
    wr(3'd0, 8'h07); e0 = last_e;
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h03); e1 = last_e;
    rd_cap(v); chk("R4 write0 capture", v, (e1 - e0 - 1) / D);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h07); e2 = last_e; exp1 = (e2 - e0 - 1) / D;
    rd_cap(v); chk("R4 write1 over 0 captures", v, exp1);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h07);
    rd_cap(v); chk("R4 write1 over 1 no capture", v, exp1);

    // R5 prescaler stopped: no capture; R1 stopped counter reads 0
    wr(3'd0, 8'h05);
    wr(3'd0, 8'h01);
    rd_cap(v); chk("R5 no capture when prescaler off", v, exp1);
    wr(3'd0, 8'h06);
    repeat (7) @(negedge clk);
    wr(3'd0, 8'h02);
    rd_cap(v); chk("R1 timer stopped holds 0", v, 0);
    wr(3'd0, 8'h04);
    wr(3'd0, 8'h02);
    rd_cap(v); chk("R1 prescaler off holds 0", v, 0);

    // R7 coherent high byte
    wr(3'd0, 8'h06);
    wr(3'd0, 8'h07); e0 = last_e;
    repeat (800) @(negedge clk);
    wr(3'd0, 8'h03); e1 = last_e; exp1 = (e1 - e0 - 1) / D;
    rd(3'd6, b); chk("R7 low byte", b, exp1 & 8'hFF);
    repeat (800) @(negedge clk);
    wr(3'd0, 8'h03); e2 = last_e; exp2 = (e2 - e0 - 1) / D;
    rd(3'd7, b); chk("R7 high frozen", b, (exp1 >> 8) & 8'hFF);
    rd_cap(v); chk("R7 new value", v, exp2);

    // R8 compare sweep
    for (int c = 1; c <= 10; c++) begin
      wr(3'd0, 8'h06);
      wr(3'd2, c[7:0]); wr(3'd3, 8'h00);
      wr(3'd4, 8'(c + 3)); wr(3'd5, 8'h00);
      n0 = 0; n1 = 0;
      wr(3'd0, 8'h07); e0 = last_e;
      repeat ((c + 5) * D) @(negedge clk);
      chk("R8 irq0 cycle", f0, e0 + c * D);
      chk("R8 irq0 single", n0, 1);
      chk("R8 irq1 cycle", f1, e0 + (c + 3) * D);
      chk("R8 irq1 single", n1, 1);
    end

    // R9 command encoding
    wr(3'd1, 8'h01); chk("R9 set", tmr_out, 1);
    wr(3'd1, 8'h03); chk("R9 keep", tmr_out, 1);
    rd(3'd1, b);     chk("R9 readback", b, 8'h23);
    wr(3'd1, 8'h02); chk("R9 clear", tmr_out, 0);
    wr(3'd1, 8'h00); chk("R9 invert 0", tmr_out, 1);
    wr(3'd1, 8'h00); chk("R9 invert 1", tmr_out, 0);

    // R10 event toggles
    wr(3'd0, 8'h06);
    wr(3'd2, 8'd5); wr(3'd4, 8'd8);
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h07);
    repeat (12 * D) @(negedge clk);
    chk("R10 cmp0 enabled only", tmr_out, 1);
    wr(3'd0, 8'h06);
    wr(3'd1, 8'h0B);
    wr(3'd0, 8'h07);
    repeat (12 * D) @(negedge clk);
    chk("R10 cmp1 enabled only", tmr_out, 0);
    wr(3'd1, 8'h13);
    wr(3'd0, 8'h03); chk("R10 capture toggles", tmr_out, 1);
    wr(3'd1, 8'h03);
    wr(3'd0, 8'h03); chk("R10 capture disabled", tmr_out, 1);

    done = 1;
    finish_run();
  end
endmodule